// File: doc/BRIEF.md
# Multi-Mode 16-bit Capture Timer

This block is a 16-bit down-counter with a reload latch. Software reaches it over an 8-bit register bus as a low byte and a high byte. A two-bit mode input selects one of four behaviours. In plain timing the counter steps on an internal count enable. In event counting it steps on edges of an external pin. The two measurement modes use the same pin to reload the counter and to capture the count it held at that instant. When the counter passes zero it reloads from the latch and raises an underflow interrupt pulse. An accepted measurement edge raises an edge interrupt pulse.

The bus is made atomic by ordering. A low-byte write is only buffered, and the following high-byte write moves the whole 16-bit word into the latch and the counter in one cycle. A high-byte read freezes the low byte, so the low-byte read that follows belongs to the same 16-bit value. A captured value stays put until software finishes reading it, even if further edges arrive first. The external pin goes through a two-flop synchronizer before its edges are detected.

Top module: `capture_timer16`

## Requirements
- R1: After reset the counter, the latch and the capture register are zero, and both interrupt outputs are low.
- R2: A write with `reg_sel`=0 (low byte) only stores the byte in a buffer. The counter value read back does not change.
- R3: A write with `reg_sel`=1 (high byte) loads {written byte, buffered low byte} into both the latch and the counter on that clock edge.
- R4: In timer mode (`mode`=2'b00), each clock with `count_en` high decrements the counter by one. A tick that finds the counter at zero reloads it from the latch instead, so a latch value n divides the ticks by n+1.
- R5: Each underflow drives `irq_uflow` high for exactly the one cycle after the clock edge on which the underflow happened.
- R6: A high-byte read (`rd_en`=1, `reg_sel`=1) returns the upper byte combinationally and freezes the lower byte. A later low-byte read returns that frozen byte even if the counter has moved in between.
- R7: In timer and event modes a read returns the live counter value.
- R8: In period mode (`mode`=2'b10) the active edge is rising when `edge_fall`=0 and falling when `edge_fall`=1. An active edge on `cap_pin` pulses `irq_edge`, captures the current count and reloads the counter from the latch. The reload takes effect on the third clock edge after the pin changes. The inactive edge does nothing.
- R9: In the measurement modes a read returns the captured value. Once a value has been captured it is not overwritten by later edges until a low-byte read completes.
- R10: In pulse-width mode (`mode`=2'b11) both rising and falling edges capture, reload and pulse `irq_edge`, whatever the value of `edge_fall`.
- R11: In event mode (`mode`=2'b01) the counter steps on each active edge of `cap_pin`, selected by `edge_fall`. It ignores `count_en`, and it underflows and reloads as in R4.
- R12: In timer and event modes, edges on `cap_pin` never reload the counter and never pulse `irq_edge`.
- R13: If a measurement edge and an underflowing tick fall on the same clock edge, the counter takes the latch value once and the capture stores zero. `irq_uflow` and `irq_edge` pulse together in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_en | input | 1 | Write strobe for the selected byte |
| rd_en | input | 1 | Read strobe for the selected byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected byte |
| count_en | input | 1 | Internal count tick (timer and measurement modes) |
| cap_pin | input | 1 | External asynchronous edge input |
| mode | input | 2 | 00 timer, 01 event, 10 period, 11 pulse width |
| edge_fall | input | 1 | Active edge: 0 rising, 1 falling |
| irq_uflow | output | 1 | One-cycle underflow interrupt pulse |
| irq_edge | output | 1 | One-cycle measurement edge interrupt pulse |

## Verification
The interesting coincidence is a measurement edge that arrives on the same clock edge as a tick that finds the counter at zero. In that cycle both the edge reload and the underflow reload want the counter. The bench sets up the collision by counting the counter down to zero and raising the pin. It then holds `count_en` high for exactly the cycle in which the synchronized edge is acted on. The result is judged by seeing both interrupt pulses at the same sample point, a capture of zero, and the latch value in the counter with no extra decrement.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_EVENT  = 2'b01,
        MODE_PERIOD = 2'b10,
        MODE_PWIDTH = 2'b11
    } ctm_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_s;

    function automatic logic is_measure(ctm_mode_e m);
        return (m == MODE_PERIOD) || (m == MODE_PWIDTH);
    endfunction

    function automatic logic edge_active(ctm_mode_e m, logic fall_sel, edge_s e);
        if (m == MODE_PWIDTH)
            return e.rise | e.fall;
        return fall_sel ? e.fall : e.rise;
    endfunction

endpackage

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync
    import ctm_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_s ev
);
    // sh[0] .. sh[STAGES-1] synchronize, sh[STAGES] holds the previous sample
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        ev.rise = sh[STAGES-1] & ~sh[STAGES];
        ev.fall = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/ctm_regif.sv
module ctm_regif #(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic [CNT_W-1:0]   rd_src,
    output logic               ld_en,
    output logic [CNT_W-1:0]   ld_val,
    output logic               rd_lo_done,
    output logic [CNT_W/2-1:0] rd_data,
    output logic [CNT_W/2-1:0] wbuf_o
);
    localparam int unsigned HALF = CNT_W / 2;

    logic [HALF-1:0] wbuf_q;
    logic [HALF-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            snap_q <= '0;
        end else begin
            if (wr_en && !reg_sel)
                wbuf_q <= wr_data;
            if (rd_en && reg_sel)
                snap_q <= rd_src[HALF-1:0];
        end
    end

    always_comb begin
        ld_en      = wr_en && reg_sel;
        ld_val     = {wr_data, wbuf_q};
        rd_lo_done = rd_en && !reg_sel;
        rd_data    = reg_sel ? rd_src[CNT_W-1:HALF] : snap_q;
        wbuf_o     = wbuf_q;
    end
endmodule

// File: rtl/ctm_core.sv
module ctm_core
    import ctm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctm_mode_e        mode,
    input  logic             tick,
    input  logic             edge_hit,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             rd_lo_done,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] latch,
    output logic [CNT_W-1:0] cap,
    output logic             held,
    output logic             irq_uflow,
    output logic             irq_edge
);
    logic reload_edge;
    logic terminal;

    always_comb begin
        reload_edge = is_measure(mode) && edge_hit;
        terminal    = tick && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            latch     <= '0;
            cap       <= '0;
            held      <= 1'b0;
            irq_uflow <= 1'b0;
            irq_edge  <= 1'b0;
        end else begin
            irq_uflow <= terminal && !ld_en;
            irq_edge  <= reload_edge;

            if (ld_en) begin
                latch <= ld_val;
                cnt   <= ld_val;
            end else if (reload_edge) begin
                cnt <= latch;
            end else if (tick) begin
                cnt <= terminal ? latch : cnt - CNT_W'(1);
            end

            if (reload_edge && (!held || rd_lo_done)) begin
                cap  <= cnt;
                held <= 1'b1;
            end else if (rd_lo_done) begin
                held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/capture_timer16.sv
module capture_timer16
    import ctm_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W/2-1:0] rd_data,
    input  logic               count_en,
    input  logic               cap_pin,
    input  logic [1:0]         mode,
    input  logic               edge_fall,
    output logic               irq_uflow,
    output logic               irq_edge
);
    localparam int unsigned HALF = CNT_W / 2;

    ctm_mode_e        mode_e;
    edge_s            ev;
    logic             edge_act;
    logic             tick;
    logic             ld_en;
    logic [CNT_W-1:0] ld_val;
    logic             rd_lo_done;
    logic [CNT_W-1:0] rd_src;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cap_q;
    logic             held_q;
    logic [HALF-1:0]  wbuf_q;

    always_comb begin
        mode_e   = ctm_mode_e'(mode);
        edge_act = edge_active(mode_e, edge_fall, ev);
        tick     = (mode_e == MODE_EVENT) ? edge_act : count_en;
        rd_src   = is_measure(mode_e) ? cap_q : cnt_q;
    end

    ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (cap_pin),
        .ev  (ev)
    );

    ctm_regif #(.CNT_W(CNT_W)) u_regif (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_data    (wr_data),
        .rd_src     (rd_src),
        .ld_en      (ld_en),
        .ld_val     (ld_val),
        .rd_lo_done (rd_lo_done),
        .rd_data    (rd_data),
        .wbuf_o     (wbuf_q)
    );

    ctm_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .tick       (tick),
        .edge_hit   (edge_act),
        .ld_en      (ld_en),
        .ld_val     (ld_val),
        .rd_lo_done (rd_lo_done),
        .cnt        (cnt_q),
        .latch      (latch_q),
        .cap        (cap_q),
        .held       (held_q),
        .irq_uflow  (irq_uflow),
        .irq_edge   (irq_edge)
    );
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_sel,
    input logic               wr_en,
    input logic               rd_en,
    input logic [CNT_W/2-1:0] wr_data,
    input logic [CNT_W/2-1:0] rd_data,
    input logic               count_en,
    input logic [1:0]         mode,
    input logic               irq_uflow,
    input logic               irq_edge,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [CNT_W-1:0]   latch_q,
    input logic [CNT_W-1:0]   cap_q,
    input logic               held_q,
    input logic [CNT_W-1:0]   rd_src,
    input logic [CNT_W/2-1:0] wbuf_q
);
    a_r3_high_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel) |=> (cnt_q == $past({wr_data, wbuf_q})) && (latch_q == $past({wr_data, wbuf_q})));

    a_r4_timer_decrement: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && count_en && !(wr_en && reg_sel) && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    a_r4_zero_reloads: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && count_en && !(wr_en && reg_sel) && cnt_q == '0) |=> (cnt_q == $past(latch_q)) && irq_uflow);

    a_r6_low_snapshot: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel) |=> (reg_sel || rd_data == $past(rd_src[CNT_W/2-1:0])));

    a_r9_capture_held: assert property (@(posedge clk) disable iff (rst)
        (held_q && !(rd_en && !reg_sel)) |=> $stable(cap_q));

    a_r12_edge_irq_only_measure: assert property (@(posedge clk) disable iff (rst)
        irq_edge |-> $past(mode[1]));
endmodule

bind capture_timer16 ctm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .count_en  (count_en),
    .mode      (mode),
    .irq_uflow (irq_uflow),
    .irq_edge  (irq_edge),
    .cnt_q     (cnt_q),
    .latch_q   (latch_q),
    .cap_q     (cap_q),
    .held_q    (held_q),
    .rd_src    (rd_src),
    .wbuf_q    (wbuf_q)
);

// File: tb/capture_timer16_tb.sv
module capture_timer16_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       count_en = 1'b0;
    logic       cap_pin = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       edge_fall = 1'b0;
    logic       irq_uflow;
    logic       irq_edge;

    int n_cmp = 0;
    int n_bad = 0;
    int uf_n  = 0;
    int eg_n  = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    capture_timer16 u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .count_en(count_en), .cap_pin(cap_pin),
        .mode(mode), .edge_fall(edge_fall), .irq_uflow(irq_uflow), .irq_edge(irq_edge)
    );

    always @(negedge clk) begin
        if (!rst && irq_uflow) uf_n++;
        if (!rst && irq_edge)  eg_n++;
    end

    // {load value, ticks, expected count, expected underflows}
    localparam logic [55:0] VEC [0:7] = '{
        {16'd5,      16'd3,   16'd2,      8'd0},
        {16'd5,      16'd6,   16'd5,      8'd1},
        {16'd5,      16'd13,  16'd4,      8'd2},
        {16'd0,      16'd4,   16'd0,      8'd4},
        {16'h1234,   16'd2,   16'h1232,   8'd0},
        {16'h0100,   16'd257, 16'h0100,   8'd1},
        {16'hFFFF,   16'd1,   16'hFFFE,   8'd0},
        {16'd3,      16'd4,   16'd3,      8'd1}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write16(logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; reg_sel = 1'b0; wr_data = v[7:0];
        @(negedge clk); reg_sel = 1'b1; wr_data = v[15:8];
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1; reg_sel = 1'b1;
        #1 v[15:8] = rd_data;
        @(negedge clk); reg_sel = 1'b0;
        #1 v[7:0] = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(int n);
        if (n > 0) begin
            @(negedge clk); count_en = 1'b1;
            repeat (n) @(negedge clk);
            count_en = 1'b0;
        end
    endtask

    task automatic pin(logic v);
        @(negedge clk); cap_pin = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        logic [7:0]  hi;
        logic [7:0]  lo;
        int          uf0;
        int          eg0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1 chk("R1 irq_uflow", irq_uflow, 0);
        chk("R1 irq_edge", irq_edge, 0);
        read16(rv); chk("R1 count", rv, 0);
        mode = 2'b10; read16(rv); chk("R1 capture", rv, 0);
        mode = 2'b00;

        // R4/R5 table of reload/divide vectors
        for (int i = 0; i < 8; i++) begin
            write16(VEC[i][55:40]);
            uf0 = uf_n;
            tick(int'(VEC[i][39:24]));
            @(negedge clk);
            read16(rv);
            chk($sformatf("R4 vec%0d count", i), rv, VEC[i][23:8]);
            chk($sformatf("R5 vec%0d underflows", i), uf_n - uf0, VEC[i][7:0]);
        end

        // R5 single-cycle pulse
        write16(16'd0);
        @(negedge clk); count_en = 1'b1;
        @(negedge clk); count_en = 1'b0;
        #1 chk("R5 pulse high", irq_uflow, 1);
        @(negedge clk); #1 chk("R5 pulse ends", irq_uflow, 0);

        // R2 low byte only buffers; R3 high byte commits buffered low
        write16(16'h1234);
        @(negedge clk); wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'hAA;
        @(negedge clk); wr_en = 1'b0;
        read16(rv); chk("R2 low write no effect", rv, 16'h1234);
        @(negedge clk); wr_en = 1'b1; reg_sel = 1'b1; wr_data = 8'h56;
        @(negedge clk); wr_en = 1'b0;
        read16(rv); chk("R3 high write commits", rv, 16'h56AA);

        // R6 snapshot coherence, R7 live read
        write16(16'h0100);
        @(negedge clk); rd_en = 1'b1; reg_sel = 1'b1;
        #1 hi = rd_data;
        @(negedge clk); rd_en = 1'b0; count_en = 1'b1;
        @(negedge clk); count_en = 1'b0;
        @(negedge clk); rd_en = 1'b1; reg_sel = 1'b0;
        #1 lo = rd_data;
        @(negedge clk); rd_en = 1'b0;
        chk("R6 coherent pair", {hi, lo}, 16'h0100);
        read16(rv); chk("R7 live count", rv, 16'h00FF);

        // R8 period mode, rising edge
        mode = 2'b10; edge_fall = 1'b0;
        write16(16'd100);
        tick(10);
        eg0 = eg_n;
        pin(1'b1);
        chk("R8 edge irq", eg_n - eg0, 1);
        read16(rv); chk("R8 capture", rv, 16'd90);
        mode = 2'b00; read16(rv); chk("R8 reload", rv, 16'd100);

        // R8 inactive edge, R9 hold
        mode = 2'b10;
        eg0 = eg_n;
        pin(1'b0);
        chk("R8 inactive edge ignored", eg_n - eg0, 0);
        tick(10);
        pin(1'b1);
        tick(5);
        pin(1'b0);
        pin(1'b1);
        read16(rv); chk("R9 first capture held", rv, 16'd90);
        tick(2);
        pin(1'b0);
        pin(1'b1);
        read16(rv); chk("R9 capture after read", rv, 16'd98);

        // R8 falling-edge select
        edge_fall = 1'b1;
        eg0 = eg_n;
        pin(1'b0);
        chk("R8 falling active", eg_n - eg0, 1);
        pin(1'b1);
        chk("R8 rising inactive", eg_n - eg0, 1);
        read16(rv);

        // R10 pulse width: both edges
        mode = 2'b11;
        write16(16'd50);
        tick(3);
        eg0 = eg_n;
        pin(1'b0);
        read16(rv); chk("R10 falling capture", rv, 16'd47);
        tick(4);
        pin(1'b1);
        read16(rv); chk("R10 rising capture", rv, 16'd46);
        chk("R10 edge irqs", eg_n - eg0, 2);

        // R12 timer mode ignores edges
        mode = 2'b00; edge_fall = 1'b0;
        write16(16'd20);
        eg0 = eg_n;
        pin(1'b0);
        pin(1'b1);
        chk("R12 timer no edge irq", eg_n - eg0, 0);
        read16(rv); chk("R12 timer no reload", rv, 16'd20);

        // R11 event mode
        mode = 2'b01;
        pin(1'b0);
        write16(16'd10);
        eg0 = eg_n;
        @(negedge clk); count_en = 1'b1;
        pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0); pin(1'b1);
        count_en = 1'b0;
        read16(rv); chk("R11 event count", rv, 16'd7);
        chk("R12 event no edge irq", eg_n - eg0, 0);
        pin(1'b0);
        write16(16'd1);
        uf0 = uf_n;
        pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0);
        read16(rv); chk("R11 event reload", rv, 16'd1);
        chk("R11 event underflow", uf_n - uf0, 1);

        // R13 collision of edge reload and underflow
        mode = 2'b10; edge_fall = 1'b0;
        write16(16'd2);
        tick(2);
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); count_en = 1'b1;
        @(negedge clk); count_en = 1'b0;
        #1 chk("R13 uflow same cycle", irq_uflow, 1);
        chk("R13 edge same cycle", irq_edge, 1);
        read16(rv); chk("R13 capture zero", rv, 16'd0);
        mode = 2'b00; read16(rv); chk("R13 single reload", rv, 16'd2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule